// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, from the destination address in the first six bytes of each frame, whether the frame is kept or discarded. Bytes arrive one per accepted beat. The first byte of a frame carries a start marker and the last byte carries an end marker. The filter never stalls the stream: `in_ready` is always high, so an upstream source never sees back-pressure, and a byte is consumed on every cycle in which `in_valid` is high.

Four match paths are combined. Two programmable station addresses are compared exactly. An all-ones broadcast address is recognised. A 64-bit group hash table is indexed by an XOR fold of the address. Each path is gated by a bit of a receive control word. The configuration is captured when a frame starts, so the whole frame is judged against one consistent setting. One cycle after the sixth byte, a verdict strobe is raised and the accept flag is set. That flag is held until the next frame starts. A frame that ends before its twelfth byte is treated as a runt: its accept flag is forced low and a separate drop strobe is raised.

Top module: `rx_dest_filter`

## Requirements
- R1: `in_ready` is high at all times, and a beat is any cycle with `in_valid` high. A frame begins on a beat with `in_sof` high and ends on a beat with `in_eof` high. Beats that arrive between the end of one frame and the next start marker are ignored. They raise no strobe and do not change `verdict_accept`.
- R2: A station address is 48 bits formed as {hi[15:0], lo[31:0]}, with byte k of the address in bits 8k+7:8k, so the first address byte on the wire lands in lo[7:0]. When rx_ctrl[0] is set, a destination equal to station address 0 is accepted.
- R3: When rx_ctrl[1] is set, a destination equal to station address 1 is accepted.
- R4: When rx_ctrl[3] is set, the destination FF:FF:FF:FF:FF:FF is accepted.
- R5: The hash index is the XOR of the eight 6-bit slices of the 48-bit destination, where slice s is bits 6s+5:6s. Index i below 32 selects bit i of `grp_lo`, and index i of 32 or more selects bit i-32 of `grp_hi`. A set bit accepts the frame.
- R6: The hash lookup is used only when bit 0 of the first destination byte (the group bit) is 1, or when rx_ctrl[2] is set. Otherwise it cannot accept.
- R7: `verdict_valid` pulses for exactly one cycle, in the cycle after the beat that carries the sixth byte. In that cycle `verdict_accept` is the OR of all enabled paths that match.
- R8: `verdict_accept` holds its value until the next start beat, and it reads 0 in the cycle after that beat. It is 0 after reset.
- R9: A frame whose end beat is among its first 11 bytes is a runt. In the cycle after that end beat, `runt_drop` pulses for one cycle and `verdict_accept` is 0. For a 6-byte frame, this cycle coincides with `verdict_valid`.
- R10: The configuration inputs are sampled on the start beat. Changes made later in the frame apply only to the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_ready | output | 1 | Always 1; the filter never stalls |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| sta0_lo | input | 32 | Station address 0, bytes 0..3 |
| sta0_hi | input | 16 | Station address 0, bytes 4..5 |
| sta1_lo | input | 32 | Station address 1, bytes 0..3 |
| sta1_hi | input | 16 | Station address 1, bytes 4..5 |
| grp_lo | input | 32 | Hash table bits for indices 0..31 |
| grp_hi | input | 32 | Hash table bits for indices 32..63 |
| rx_ctrl | input | 4 | Path enables: [0] station 0, [1] station 1, [2] hash individual addresses, [3] broadcast |
| verdict_valid | output | 1 | One-cycle strobe after the sixth byte |
| verdict_accept | output | 1 | Accept flag, held until the next frame starts |
| runt_drop | output | 1 | One-cycle strobe for a frame shorter than 12 bytes |

## Verification
The address verdict and the runt decision can fall in the same cycle. This happens when the end marker sits on the sixth byte, because both outcomes then come from a single beat. The bench sends a 6-byte frame to an enabled station address and counts the cycles in which `verdict_valid` and `runt_drop` are high together. It expects exactly one such cycle, with `verdict_accept` low. Frames of 11 and 12 bytes on either side of the runt limit confirm that the override applies only below twelve bytes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int HASH_W     = 6;
  localparam int TBL_W      = 1 << HASH_W;
  localparam int CTRL_W     = 4;

  // control word bit positions
  localparam int CTL_STA0   = 0;
  localparam int CTL_STA1   = 1;
  localparam int CTL_HASHIN = 2;
  localparam int CTL_BCAST  = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] sta0;
    logic [ADDR_W-1:0] sta1;
    logic [TBL_W-1:0]  grp_tbl;
    logic [CTRL_W-1:0] ctrl;
  } rxf_cfg_t;
endpackage

// File: rtl/rxf_collect.sv
// Tracks frame position, assembles the destination address and holds the
// configuration snapshot taken on the start beat.
module rxf_collect
  import rxf_pkg::*;
#(
  parameter int MIN_LEN = 12,
  localparam int CNT_W  = $clog2(MIN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              sof,
  input  logic              eof,
  input  logic [7:0]        data,
  input  rxf_cfg_t          cfg_in,
  output rxf_cfg_t          cfg_eff,
  output logic [ADDR_W-1:0] addr_now,
  output logic              frame_beat,
  output logic [CNT_W-1:0]  byte_idx,
  output logic              at_decide,
  output logic              at_runt
);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] RUNT_MAX  = CNT_W'(MIN_LEN - 2);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(MIN_LEN);

  logic             in_frame;
  logic [CNT_W-1:0] cnt_q;
  logic [ADDR_W-1:0] addr_q;
  rxf_cfg_t         cfg_q;

  assign byte_idx   = sof ? '0 : cnt_q;
  assign frame_beat = beat && (sof || in_frame);
  assign at_decide  = frame_beat && (byte_idx == LAST_ADDR);
  assign at_runt    = frame_beat && eof && (byte_idx <= RUNT_MAX);
  assign cfg_eff    = (beat && sof) ? cfg_in : cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      cnt_q    <= '0;
    end else if (frame_beat) begin
      in_frame <= !eof;
      if (sof)
        cnt_q <= CNT_W'(1);
      else if (cnt_q < CNT_SAT)
        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (beat && sof)
      cfg_q <= cfg_in;
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_slot
    localparam logic [CNT_W-1:0] SLOT = CNT_W'(g);
    logic hit;
    assign hit = frame_beat && (byte_idx == SLOT);
    always_ff @(posedge clk) begin
      if (!rst_n)
        addr_q[g*8 +: 8] <= '0;
      else if (hit)
        addr_q[g*8 +: 8] <= data;
    end
    assign addr_now[g*8 +: 8] = hit ? data : addr_q[g*8 +: 8];
  end
endmodule

// File: rtl/rxf_hash.sv
// XOR fold of the address into a table index.
module rxf_hash
  import rxf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [HASH_W-1:0] idx
);
  localparam int SLICES = (ADDR_W + HASH_W - 1) / HASH_W;
  localparam int PAD_W  = SLICES * HASH_W;

  logic [PAD_W-1:0]  padded;
  logic [HASH_W-1:0] fold [SLICES+1];

  assign padded  = PAD_W'(addr);
  assign fold[0] = '0;

  for (genvar s = 0; s < SLICES; s++) begin : g_fold
    assign fold[s+1] = fold[s] ^ padded[s*HASH_W +: HASH_W];
  end

  assign idx = fold[SLICES];
endmodule

// File: rtl/rxf_match.sv
// Combines the four match paths into one accept bit.
module rxf_match
  import rxf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  rxf_cfg_t          cfg,
  output logic              accept
);
  logic [HASH_W-1:0] hidx;
  logic hit_sta0, hit_sta1, hit_bcast, hit_hash, hash_on;

  rxf_hash u_hash (
    .addr (addr),
    .idx  (hidx)
  );

  assign hit_sta0  = cfg.ctrl[CTL_STA0]  && (addr == cfg.sta0);
  assign hit_sta1  = cfg.ctrl[CTL_STA1]  && (addr == cfg.sta1);
  assign hit_bcast = cfg.ctrl[CTL_BCAST] && (&addr);
  assign hash_on   = addr[0] || cfg.ctrl[CTL_HASHIN];
  assign hit_hash  = hash_on && cfg.grp_tbl[hidx];
  assign accept    = hit_sta0 || hit_sta1 || hit_bcast || hit_hash;
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int MIN_LEN = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [31:0] sta0_lo,
  input  logic [15:0] sta0_hi,
  input  logic [31:0] sta1_lo,
  input  logic [15:0] sta1_hi,
  input  logic [31:0] grp_lo,
  input  logic [31:0] grp_hi,
  input  logic [3:0]  rx_ctrl,
  output logic        verdict_valid,
  output logic        verdict_accept,
  output logic        runt_drop
);
  localparam int CNT_W = $clog2(MIN_LEN + 1);

  rxf_cfg_t          cfg_in, cfg_eff;
  logic [ADDR_W-1:0] addr_now;
  logic              frame_beat, at_decide, at_runt, accept;
  logic [CNT_W-1:0]  byte_idx;

  assign in_ready       = 1'b1;
  assign cfg_in.sta0    = {sta0_hi, sta0_lo};
  assign cfg_in.sta1    = {sta1_hi, sta1_lo};
  assign cfg_in.grp_tbl = {grp_hi, grp_lo};
  assign cfg_in.ctrl    = rx_ctrl;

  rxf_collect #(.MIN_LEN(MIN_LEN)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (in_valid),
    .sof        (in_sof),
    .eof        (in_eof),
    .data       (in_data),
    .cfg_in     (cfg_in),
    .cfg_eff    (cfg_eff),
    .addr_now   (addr_now),
    .frame_beat (frame_beat),
    .byte_idx   (byte_idx),
    .at_decide  (at_decide),
    .at_runt    (at_runt)
  );

  rxf_match u_match (
    .addr   (addr_now),
    .cfg    (cfg_eff),
    .accept (accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      runt_drop      <= 1'b0;
      verdict_accept <= 1'b0;
    end else begin
      verdict_valid <= at_decide;
      runt_drop     <= at_runt;
      if (at_runt)
        verdict_accept <= 1'b0;
      else if (at_decide)
        verdict_accept <= accept;
      else if (frame_beat && in_sof)
        verdict_accept <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int MIN_LEN    = 12,
  parameter int ADDR_BYTES = 6,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eof,
  input logic             frame_beat,
  input logic [CNT_W-1:0] byte_idx,
  input logic             verdict_valid,
  input logic             verdict_accept,
  input logic             runt_drop
);
  AST_VERDICT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(frame_beat && (byte_idx == CNT_W'(ADDR_BYTES - 1)))); // R7
  AST_ACCEPT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(verdict_accept) |-> verdict_valid); // R7
  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> !verdict_accept); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(verdict_accept)); // R8
  AST_RUNT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    runt_drop |-> !verdict_accept); // R9
  AST_RUNT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    runt_drop |-> $past(frame_beat && in_eof && (byte_idx < CNT_W'(MIN_LEN - 1)))); // R9
endmodule

bind rx_dest_filter rxf_checker #(
  .MIN_LEN    (MIN_LEN),
  .ADDR_BYTES (rxf_pkg::ADDR_BYTES),
  .CNT_W      (CNT_W)
) u_rxf_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_sof         (in_sof),
  .in_eof         (in_eof),
  .frame_beat     (frame_beat),
  .byte_idx       (byte_idx),
  .verdict_valid  (verdict_valid),
  .verdict_accept (verdict_accept),
  .runt_drop      (runt_drop)
);

// File: tb/test_rx_dest_filter.sv
module test_rx_dest_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic [31:0] sta0_lo, sta1_lo, grp_lo = '0, grp_hi = '0;
  logic [15:0] sta0_hi, sta1_hi;
  logic [3:0] rx_ctrl = '0;
  logic in_ready, verdict_valid, verdict_accept, runt_drop;

  localparam logic [47:0] STA0 = 48'h0A0B0C0D0E02;
  localparam logic [47:0] STA1 = 48'h5A4B3C2D1E40;
  localparam logic [47:0] BC   = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] G1   = 48'h000000000001; // hash index 1
  localparam logic [47:0] G33  = 48'h000000000021; // hash index 33
  localparam logic [47:0] GX   = 48'h800000000001; // slices 0 and 7 fold to 33
  localparam logic [47:0] IND  = 48'h123456789A02;

  assign sta0_lo = STA0[31:0];
  assign sta0_hi = STA0[47:32];
  assign sta1_lo = STA1[31:0];
  assign sta1_hi = STA1[47:32];

  rx_dest_filter i_rx_dest_filter (.*);

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  int nv, nr, nboth, tv, t5;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (verdict_valid) begin nv++; tv = cyc; end
    if (runt_drop) nr++;
    if (verdict_valid && runt_drop) nboth++;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [5:0] h = '0;
    for (int s = 0; s < 8; s++) h ^= a[6*s +: 6];
    return h;
  endfunction

  // hmode: 0 empty table, 1 only the hit bit, 2 all but the hit bit,
  // 3 same bit position in the other table word
  task automatic set_cfg(input logic [3:0] ctrl, input int hmode, input logic [47:0] dst);
    logic [63:0] t;
    logic [5:0] h = ref_hash(dst);
    case (hmode)
      1: t = 64'd1 << h;
      2: t = ~(64'd1 << h);
      3: t = 64'd1 << (h ^ 6'd32);
      default: t = '0;
    endcase
    @(negedge clk);
    rx_ctrl = ctrl;
    grp_lo = t[31:0];
    grp_hi = t[63:32];
  endtask

  task automatic send_frame(input logic [47:0] dst, input int len,
                            input int chg_at, input logic [3:0] chg_ctrl);
    nv = 0; nr = 0; nboth = 0; tv = -1; t5 = -1;
    for (int i = 0; i < len; i++) begin
      if (i == 3) begin @(negedge clk); in_valid = 1'b0; end
      @(negedge clk);
      if (i == chg_at) rx_ctrl = chg_ctrl;
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_eof = (i == len - 1);
      in_data = (i < 6) ? dst[8*i +: 8] : 8'(i);
      if (i == 5) t5 = cyc;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [47:0] dst;
    logic [3:0]  ctrl;
    logic [1:0]  hmode;
    logic [7:0]  len;
    logic        acc;
    logic        runt;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{STA0, 4'h1, 2'd0, 8'd20, 1'b1, 1'b0, 4'd2},  // R2
    '{STA0, 4'h2, 2'd0, 8'd20, 1'b0, 1'b0, 4'd2},  // R2
    '{STA1, 4'h2, 2'd0, 8'd16, 1'b1, 1'b0, 4'd3},  // R3
    '{STA1, 4'h1, 2'd0, 8'd16, 1'b0, 1'b0, 4'd3},  // R3
    '{BC,   4'h8, 2'd0, 8'd14, 1'b1, 1'b0, 4'd4},  // R4
    '{BC,   4'h0, 2'd0, 8'd14, 1'b0, 1'b0, 4'd4},  // R4
    '{G1,   4'h0, 2'd1, 8'd12, 1'b1, 1'b0, 4'd5},  // R5 low word
    '{G1,   4'h0, 2'd3, 8'd12, 1'b0, 1'b0, 4'd5},  // R5 wrong word
    '{G33,  4'h0, 2'd1, 8'd13, 1'b1, 1'b0, 4'd5},  // R5 high word
    '{G33,  4'h0, 2'd3, 8'd13, 1'b0, 1'b0, 4'd5},  // R5 wrong word
    '{GX,   4'h0, 2'd1, 8'd15, 1'b1, 1'b0, 4'd5},  // R5 top slice
    '{GX,   4'h0, 2'd2, 8'd15, 1'b0, 1'b0, 4'd5},  // R5 miss
    '{IND,  4'h0, 2'd1, 8'd20, 1'b0, 1'b0, 4'd6},  // R6 individual, no hash
    '{IND,  4'h4, 2'd1, 8'd20, 1'b1, 1'b0, 4'd6},  // R6 individual hashing on
    '{IND,  4'hF, 2'd2, 8'd20, 1'b0, 1'b0, 4'd7},  // R7 nothing matches
    '{STA1, 4'hB, 2'd2, 8'd20, 1'b1, 1'b0, 4'd7},  // R7 OR of paths
    '{STA0, 4'h1, 2'd0, 8'd11, 1'b0, 1'b1, 4'd9},  // R9 one short
    '{STA0, 4'h1, 2'd0, 8'd12, 1'b1, 1'b0, 4'd9},  // R9 at limit
    '{STA0, 4'h1, 2'd0, 8'd6,  1'b0, 1'b1, 4'd9},  // R9 same cycle
    '{BC,   4'h8, 2'd0, 8'd3,  1'b0, 1'b1, 4'd9},  // R9 no verdict
    '{STA1, 4'h3, 2'd0, 8'd5,  1'b0, 1'b1, 4'd9}   // R9 no verdict
  };

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R8 and R1
    chk("R8 reset accept", verdict_accept, 0);
    chk("R7 reset valid", verdict_valid, 0);
    chk("R9 reset runt", runt_drop, 0);
    chk("R1 ready in reset", in_ready, 1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i].ctrl, int'(VEC[i].hmode), VEC[i].dst);
      send_frame(VEC[i].dst, int'(VEC[i].len), -1, 4'h0);
      chk($sformatf("R%0d vec %0d accept", VEC[i].rq, i), verdict_accept, VEC[i].acc);
      chk($sformatf("R7 vec %0d verdict count", i), nv, (VEC[i].len >= 6) ? 1 : 0);
      if (VEC[i].len >= 6)
        chk($sformatf("R7 vec %0d verdict cycle", i), tv, t5 + 1);
      chk($sformatf("R9 vec %0d runt count", i), nr, VEC[i].runt);
      if (VEC[i].len == 6)
        chk("R9 verdict and runt together", nboth, 1);
    end

    // R8: accepted verdict held over idle, cleared by the next start beat
    set_cfg(4'h1, 0, STA0);
    send_frame(STA0, 20, -1, 4'h0);
    repeat (20) @(negedge clk);
    chk("R8 held over idle", verdict_accept, 1);
    in_valid = 1'b1; in_sof = 1'b1; in_data = 8'h00;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    chk("R8 cleared after start", verdict_accept, 0);
    in_valid = 1'b1; in_eof = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    @(negedge clk);

    // R1: stray beats outside a frame are ignored
    set_cfg(4'h1, 0, STA0);
    send_frame(STA0, 14, -1, 4'h0);
    nv = 0; nr = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = STA0[8*(i % 6) +: 8];
    end
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk("R1 stray beats no verdict", nv, 0);
    chk("R1 stray beats no runt", nr, 0);
    chk("R1 stray beats accept kept", verdict_accept, 1);

    // R10: mid-frame config change applies to the next frame
    set_cfg(4'h1, 0, STA0);
    send_frame(STA0, 16, 2, 4'h0);
    chk("R10 disable mid-frame ignored", verdict_accept, 1);
    send_frame(STA0, 16, -1, 4'h0);
    chk("R10 disable on next frame", verdict_accept, 0);
    send_frame(STA0, 16, 1, 4'h1);
    chk("R10 enable mid-frame ignored", verdict_accept, 0);
    send_frame(STA0, 16, -1, 4'h0);
    chk("R10 enable on next frame", verdict_accept, 1);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule